// File: doc/BRIEF.md
# Fetch Address Selection and Pipeline Hazard Control

This block steers the fetch stage of a five-stage in-order pipeline and tells the pipeline registers when to stall or take a bubble. It holds a predicted fetch address in a register. Every conditional jump and every call is guessed taken, so the next guess is the fetched instruction's constant target. Every other instruction continues at its fall-through address.

When a conditional jump reaches the memory stage with a false condition, the block redirects fetch to the fall-through address saved with that jump. It also bubbles the decode and execute registers, which removes the two wrong-path instructions. A return instruction has to wait for its target to be read from the stack. While the return sits in decode, execute or memory, fetch is stalled and decode receives bubbles. Once the return reaches writeback, fetch takes the loaded value as its address. Load-use interlocks and operand forwarding are handled elsewhere.

Instruction codes used by this block: conditional/unconditional jump = 7, call = 8, return = 9. All other codes count as ordinary instructions.

Top module: `pc_hazard_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, with no hazard present, `fetch_pc` equals the parameter `RESET_PC` (default 0).
- R2: In a cycle without fetch stall in which the fetched code is 7 or 8, the predicted address becomes `f_valc` at the next clock edge.
- R3: In a cycle without fetch stall in which the fetched code is any value other than 7 or 8, the predicted address becomes `f_valp` at the next clock edge.
- R4: When `m_icode` is 7 and `m_cnd` is 0, `fetch_pc` equals `m_valp` in the same cycle.
- R5: Under the condition of R4, `d_bubble` and `e_bubble` are 1 and `f_stall` is 0.
- R6: When `m_icode` is 7 and `m_cnd` is 1, no recovery occurs: `e_bubble` is 0 and `fetch_pc` is the predicted address.
- R7: When any of `d_icode`, `e_icode` or `m_icode` is 9 and R4 does not apply, `f_stall` and `d_bubble` are 1 and `e_bubble` is 0. The predicted address does not change at the following edge.
- R8: When `w_icode` is 9 and R4 does not apply, `fetch_pc` equals `w_valm`.
- R9: When a recovery per R4 coincides with a return in any stage, the recovery wins: `fetch_pc` equals `m_valp` and `f_stall` is 0.
- R10: A call (code 8) in the memory stage never triggers recovery, whatever the value of `m_cnd`.
- R11: With no return in decode, execute or memory and no recovery, `f_stall`, `d_bubble` and `e_bubble` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| f_icode | input | 4 | Code of the instruction fetched this cycle |
| f_valc | input | AW | Constant target of the fetched instruction |
| f_valp | input | AW | Fall-through address of the fetched instruction |
| d_icode | input | 4 | Code held in the decode register |
| e_icode | input | 4 | Code held in the execute register |
| m_icode | input | 4 | Code held in the memory register |
| m_cnd | input | 1 | Condition result stored with the memory-stage instruction |
| m_valp | input | AW | Fall-through address stored with the memory-stage instruction |
| w_icode | input | 4 | Code held in the writeback register |
| w_valm | input | AW | Value loaded by the writeback-stage instruction |
| fetch_pc | output | AW | Address to fetch this cycle |
| f_stall | output | 1 | Hold the fetch (predicted address) register |
| d_bubble | output | 1 | Load a bubble into the decode register |
| e_bubble | output | 1 | Load a bubble into the execute register |

## Verification
The stall, bubble and override results (R4 through R11) depend only on the stage inputs. They are therefore due in the same cycle the stimulus is applied. The guessed next address (R2, R3) and the hold under a return stall (R7) become visible one rising edge later, through `fetch_pc` in the next cycle. The bench applies every stimulus on the falling edge and samples all four outputs 1 ns later. Its reference model advances its own predicted address at each rising edge, so a check on the registered address lands exactly one cycle after the fetch that caused it.

// File: rtl/pc_hazard_pkg.sv
package pc_hazard_pkg;
  localparam int ICW = 4;

  localparam logic [ICW-1:0] IC_JUMP = 4'h7;
  localparam logic [ICW-1:0] IC_CALL = 4'h8;
  localparam logic [ICW-1:0] IC_RET  = 4'h9;

  // number of stages (decode, execute, memory) in which a return blocks fetch
  localparam int RET_WAIT_STAGES = 3;

  typedef enum logic [1:0] {
    SRC_GUESS = 2'd0,
    SRC_FIX   = 2'd1,
    SRC_STACK = 2'd2
  } pc_src_e;
endpackage

// File: rtl/pc_guess_reg.sv
module pc_guess_reg
  import pc_hazard_pkg::*;
#(
  parameter int          AW       = 64,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hold,
  input  logic [ICW-1:0] icode,
  input  logic [AW-1:0]  valc,
  input  logic [AW-1:0]  valp,
  output logic [AW-1:0]  guess_q
);
  logic [AW-1:0] guess_d;
  logic          taken;

  always_comb begin
    taken   = (icode == IC_JUMP) || (icode == IC_CALL);
    guess_d = taken ? valc : valp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     guess_q <= RESET_PC;
    else if (!hold) guess_q <= guess_d;
  end

  p_hold_keeps_guess_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(guess_q));
  p_taken_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && (icode == IC_JUMP || icode == IC_CALL)) |=> guess_q == $past(valc));
  p_fallthrough_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && icode != IC_JUMP && icode != IC_CALL) |=> guess_q == $past(valp));
endmodule

// File: rtl/pc_hazard_detect.sv
module pc_hazard_detect
  import pc_hazard_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [ICW-1:0] d_icode,
  input  logic [ICW-1:0] e_icode,
  input  logic [ICW-1:0] m_icode,
  input  logic           m_cnd,
  input  logic [ICW-1:0] w_icode,
  output pc_src_e        src,
  output logic           f_stall,
  output logic           d_bubble,
  output logic           e_bubble
);
  logic [RET_WAIT_STAGES-1:0][ICW-1:0] wait_codes;
  logic [RET_WAIT_STAGES-1:0]          ret_at;
  logic                                ret_wait;
  logic                                wrong_path;

  assign wait_codes = {m_icode, e_icode, d_icode};

  for (genvar s = 0; s < RET_WAIT_STAGES; s++) begin : g_ret_scan
    assign ret_at[s] = (wait_codes[s] == IC_RET);
  end

  always_comb begin
    ret_wait   = |ret_at;
    wrong_path = (m_icode == IC_JUMP) && !m_cnd;
    f_stall    = ret_wait && !wrong_path;
    d_bubble   = wrong_path || f_stall;
    e_bubble   = wrong_path;
    if (wrong_path)             src = SRC_FIX;
    else if (w_icode == IC_RET) src = SRC_STACK;
    else                        src = SRC_GUESS;
  end

  p_recover_bubbles_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (m_icode == IC_JUMP && !m_cnd) |-> (d_bubble && e_bubble && !f_stall));
  p_taken_no_recover_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_icode == IC_JUMP && m_cnd) |-> !e_bubble);
  p_ret_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((d_icode == IC_RET || e_icode == IC_RET || m_icode == IC_RET) &&
     !(m_icode == IC_JUMP && !m_cnd)) |-> (f_stall && d_bubble && !e_bubble));
  p_call_no_recover_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (m_icode == IC_CALL) |-> (!e_bubble && src != SRC_FIX));
  p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (d_icode != IC_RET && e_icode != IC_RET && m_icode != IC_RET &&
     !(m_icode == IC_JUMP && !m_cnd)) |-> (!f_stall && !d_bubble && !e_bubble));
endmodule

// File: rtl/pc_src_mux.sv
module pc_src_mux
  import pc_hazard_pkg::*;
#(
  parameter int AW = 64
) (
  input  pc_src_e       src,
  input  logic [AW-1:0] guess,
  input  logic [AW-1:0] fix_addr,
  input  logic [AW-1:0] stack_addr,
  output logic [AW-1:0] pc
);
  always_comb begin
    unique case (src)
      SRC_FIX:   pc = fix_addr;
      SRC_STACK: pc = stack_addr;
      default:   pc = guess;
    endcase
  end
endmodule

// File: rtl/pc_hazard_ctrl.sv
module pc_hazard_ctrl
  import pc_hazard_pkg::*;
#(
  parameter int            AW       = 64,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [3:0]     f_icode,
  input  logic [AW-1:0]  f_valc,
  input  logic [AW-1:0]  f_valp,
  input  logic [3:0]     d_icode,
  input  logic [3:0]     e_icode,
  input  logic [3:0]     m_icode,
  input  logic           m_cnd,
  input  logic [AW-1:0]  m_valp,
  input  logic [3:0]     w_icode,
  input  logic [AW-1:0]  w_valm,
  output logic [AW-1:0]  fetch_pc,
  output logic           f_stall,
  output logic           d_bubble,
  output logic           e_bubble
);
  pc_src_e       src;
  logic [AW-1:0] guess;

  pc_hazard_detect u_detect (
    .clk      (clk),
    .rst_n    (rst_n),
    .d_icode  (d_icode),
    .e_icode  (e_icode),
    .m_icode  (m_icode),
    .m_cnd    (m_cnd),
    .w_icode  (w_icode),
    .src      (src),
    .f_stall  (f_stall),
    .d_bubble (d_bubble),
    .e_bubble (e_bubble)
  );

  pc_guess_reg #(.AW(AW), .RESET_PC(RESET_PC)) u_guess (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold    (f_stall),
    .icode   (f_icode),
    .valc    (f_valc),
    .valp    (f_valp),
    .guess_q (guess)
  );

  pc_src_mux #(.AW(AW)) u_mux (
    .src        (src),
    .guess      (guess),
    .fix_addr   (m_valp),
    .stack_addr (w_valm),
    .pc         (fetch_pc)
  );

  p_recover_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_icode == IC_JUMP && !m_cnd) |-> fetch_pc == m_valp);
  p_stack_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (w_icode == IC_RET && !(m_icode == IC_JUMP && !m_cnd)) |-> fetch_pc == w_valm);
  p_recover_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_icode == IC_JUMP && !m_cnd && (w_icode == IC_RET || d_icode == IC_RET))
      |-> (fetch_pc == m_valp && !f_stall));
endmodule

// File: tb/sim_pc_hazard_ctrl.sv
`timescale 1ns/1ps
module sim_pc_hazard_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  f_icode, d_icode, e_icode, m_icode, w_icode;
  logic [63:0] f_valc, f_valp, m_valp, w_valm;
  logic        m_cnd;
  logic [63:0] fetch_pc;
  logic        f_stall, d_bubble, e_bubble;

  int n_checks = 0;
  int n_fail   = 0;
  logic [63:0] ref_guess;

  always #2.5 clk = ~clk;

  pc_hazard_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .f_icode(f_icode), .f_valc(f_valc), .f_valp(f_valp),
    .d_icode(d_icode), .e_icode(e_icode), .m_icode(m_icode),
    .m_cnd(m_cnd), .m_valp(m_valp), .w_icode(w_icode), .w_valm(w_valm),
    .fetch_pc(fetch_pc), .f_stall(f_stall), .d_bubble(d_bubble), .e_bubble(e_bubble)
  );

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // apply one cycle of stage contents, compare, then advance the reference model
  task automatic step(input logic [3:0] fi, input logic [63:0] fc, input logic [63:0] fp,
                      input logic [3:0] di, input logic [3:0] ei, input logic [3:0] mi,
                      input logic mc, input logic [63:0] mp,
                      input logic [3:0] wi, input logic [63:0] wv, input string tag);
    logic wrong, waitret, stall;
    logic [63:0] exp_pc;
    f_icode = fi; f_valc = fc; f_valp = fp;
    d_icode = di; e_icode = ei; m_icode = mi; m_cnd = mc; m_valp = mp;
    w_icode = wi; w_valm = wv;
    #1;
    wrong   = (mi == 4'h7) && !mc;
    waitret = (di == 4'h9) || (ei == 4'h9) || (mi == 4'h9);
    stall   = waitret && !wrong;
    if (wrong)             exp_pc = mp;
    else if (wi == 4'h9)   exp_pc = wv;
    else                   exp_pc = ref_guess;
    check(tag, "fetch_pc", fetch_pc, exp_pc);
    check(tag, "f_stall",  {63'd0, f_stall},  {63'd0, stall});
    check(tag, "d_bubble", {63'd0, d_bubble}, {63'd0, wrong || stall});
    check(tag, "e_bubble", {63'd0, e_bubble}, {63'd0, wrong});
    if (rst_n && !stall) ref_guess = (fi == 4'h7 || fi == 4'h8) ? fc : fp;
    @(negedge clk);
  endtask

  initial begin
    #500000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    ref_guess = 64'h0;
    f_icode = 4'h1; d_icode = 4'h1; e_icode = 4'h1; m_icode = 4'h1; w_icode = 4'h1;
    f_valc = '0; f_valp = '0; m_valp = '0; w_valm = '0; m_cnd = 1'b1;
    repeat (2) @(negedge clk);
    // R1: reset value visible during reset
    step(4'h3, 64'h55, 64'h0a, 4'h1, 4'h1, 4'h1, 1'b1, 64'h0, 4'h1, 64'h0, "R1");
    rst_n = 1'b1;
    // R1 after release; fetched plain op -> R3 next
    step(4'h3, 64'h55, 64'h0a, 4'h1, 4'h1, 4'h1, 1'b1, 64'h0, 4'h1, 64'h0, "R1");
    step(4'h7, 64'h40, 64'h13, 4'h1, 4'h1, 4'h1, 1'b1, 64'h0, 4'h1, 64'h0, "R3");
    step(4'h8, 64'h80, 64'h49, 4'h1, 4'h1, 4'h1, 1'b1, 64'h0, 4'h1, 64'h0, "R2");
    step(4'h6, 64'h77, 64'h82, 4'h1, 4'h1, 4'h1, 1'b1, 64'h0, 4'h1, 64'h0, "R2");
    step(4'ha, 64'h11, 64'h84, 4'h6, 4'h1, 4'h1, 1'b1, 64'h0, 4'h1, 64'h0, "R3/R11");
    // R4 R5: wrong guess on a jump in memory
    step(4'h1, 64'h00, 64'h90, 4'h6, 4'h6, 4'h7, 1'b0, 64'h13, 4'h1, 64'h0, "R4/R5");
    step(4'h1, 64'h00, 64'h14, 4'h1, 4'h1, 4'h1, 1'b1, 64'h0, 4'h7, 64'h0, "R4");
    // R6: correct guess
    step(4'h1, 64'h00, 64'h15, 4'h6, 4'h6, 4'h7, 1'b1, 64'h99, 4'h1, 64'h0, "R6");
    // R10: call in memory with a false condition bit
    step(4'h1, 64'h00, 64'h16, 4'h1, 4'h1, 4'h8, 1'b0, 64'hab, 4'h1, 64'h0, "R10");
    // R7 then R8: return walks through decode, execute, memory, writeback
    step(4'h9, 64'h00, 64'h17, 4'h1, 4'h1, 4'h1, 1'b1, 64'h0, 4'h1, 64'h0, "R7");
    step(4'h3, 64'h33, 64'h21, 4'h9, 4'h1, 4'h1, 1'b1, 64'h0, 4'h1, 64'h0, "R7");
    step(4'h3, 64'h33, 64'h21, 4'h1, 4'h9, 4'h1, 1'b1, 64'h0, 4'h1, 64'h0, "R7");
    step(4'h3, 64'h33, 64'h21, 4'h1, 4'h1, 4'h9, 1'b1, 64'h0, 4'h1, 64'h0, "R7");
    step(4'h1, 64'h00, 64'hc2, 4'h1, 4'h1, 4'h1, 1'b1, 64'h0, 4'h9, 64'hc0, "R8");
    step(4'h1, 64'h00, 64'hc3, 4'h1, 4'h1, 4'h1, 1'b1, 64'h0, 4'h1, 64'h0, "R8");
    // R9: recovery against a return in writeback and a wrong-path return in decode
    step(4'h1, 64'h00, 64'hd1, 4'h1, 4'h1, 4'h7, 1'b0, 64'h300, 4'h9, 64'h500, "R9");
    step(4'h1, 64'h00, 64'hd2, 4'h9, 4'h1, 4'h7, 1'b0, 64'h310, 4'h1, 64'h0, "R9");
    step(4'h1, 64'h00, 64'hd3, 4'h1, 4'h9, 4'h7, 1'b0, 64'h320, 4'h1, 64'h0, "R9");
    step(4'h1, 64'h00, 64'hd4, 4'h1, 4'h1, 4'h1, 1'b1, 64'h0, 4'h1, 64'h0, "R9/R11");
    // mixed patterns against the reference model
    for (int i = 0; i < 400; i++) begin
      logic [3:0] r[5];
      for (int k = 0; k < 5; k++) r[k] = 4'(6 + ($urandom % 6));
      step(r[0], {32'd0, $urandom}, {32'd0, $urandom}, r[1], r[2], r[3], 1'($urandom),
           {32'd0, $urandom}, r[4], {32'd0, $urandom}, "R2/R3/R4/R7/R8/R11");
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule